// File: doc/BRIEF.md
# SIMD Issue Fault Gate

This block sits at the issue stage of a processor whose packed-integer SIMD unit shares architectural state with the floating-point stack unit. Each cycle it looks at one offered instruction. It then grants issue or raises one of three faults: invalid opcode, device not available, or floating-point error. It checks the emulation control bit, the task-switched control bit and a pending floating-point exception flag. Instructions that are not SIMD always pass through.

A SIMD instruction that faults is captured in a one-entry replay register, and the gate stalls. A pending floating-point exception is reported before the SIMD instruction runs. While the handler runs, nothing issues, so the shared floating-point state stays as the handler sees it. When the handler returns, the held instruction is checked again against the current control bits and, if it is clean, issued as a replay. Decisions are registered and appear one cycle after the evaluated cycle.

Top module: `simd_fault_gate`

## Requirements
- R1: After reset, and after any later reset, `issue_grant_o`, `fault_valid_o`, `issue_replay_o` and `stall_o` are 0 and `fault_vec_o` is 3'b000.
- R2: A SIMD instruction offered while `ctrl_em_i` is 1 gives `fault_vec_o` = 3'b001 (bit 0, invalid opcode) with `fault_valid_o` = 1 and `issue_grant_o` = 0 in the next cycle.
- R3: A SIMD instruction offered with `ctrl_em_i` = 0 and `ctrl_ts_i` = 1 gives `fault_vec_o` = 3'b010 (bit 1, device not available) with no grant in the next cycle.
- R4: A SIMD instruction offered with both control bits 0 and `fp_pending_i` = 1 gives `fault_vec_o` = 3'b100 (bit 2, floating-point error) with no grant in the next cycle.
- R5: When several conditions hold at once, exactly one fault bit is set. Invalid opcode wins over device not available, and device not available wins over floating-point error.
- R6: A SIMD instruction with no fault condition gives `issue_grant_o` = 1, `issue_data_o` equal to its payload, `issue_replay_o` = 0 and `fault_vec_o` = 0 in the next cycle.
- R7: A non-SIMD instruction is granted in the next cycle and raises no fault, whatever the control bits and the pending flag are.
- R8: A fault sets `stall_o` in the same cycle as `fault_valid_o`. While stalled, new offered instructions are ignored: there is no grant and no fault, and the held payload is kept.
- R9: `handler_ret_i` while stalled checks the held instruction again against the current control bits. If the instruction is clean, the next cycle shows `issue_grant_o` = 1, `issue_replay_o` = 1 and `issue_data_o` equal to the held payload, and `stall_o` drops. If the instruction faults again, a new fault is raised and the stall remains.
- R10: `fault_valid_o` is high for exactly one cycle per fault raised, and only in the cycle after an evaluated instruction.
- R11: `handler_ret_i` while not stalled has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| instr_valid_i | input | 1 | An instruction is offered for issue |
| instr_simd_i | input | 1 | The offered instruction is a packed-integer SIMD instruction |
| instr_data_i | input | DATA_W | Payload of the offered instruction |
| ctrl_em_i | input | 1 | Emulation control bit |
| ctrl_ts_i | input | 1 | Task-switched control bit |
| fp_pending_i | input | 1 | A floating-point exception is pending |
| handler_ret_i | input | 1 | The fault handler has returned |
| issue_grant_o | output | 1 | The instruction issues this cycle |
| issue_replay_o | output | 1 | The granted instruction is the replayed one |
| issue_data_o | output | DATA_W | Payload of the granted instruction |
| fault_valid_o | output | 1 | One-cycle fault strobe |
| fault_vec_o | output | 3 | One-hot fault: bit 0 invalid opcode, bit 1 device not available, bit 2 floating-point error |
| stall_o | output | 1 | The replay register is busy and new instructions are ignored |

## Verification
The checker watches several properties on every cycle. Grant and fault never appear together. The fault vector is one-hot when the strobe is high and zero otherwise. Every strobe follows an evaluated cycle. The priority holds whenever the emulation bit was set. Non-SIMD instructions are always granted. A stalled gate with no handler return produces nothing. Only the bench scenarios can show the exact fault code chosen for each mix of conditions, the payload carried through a replay, repeated faults on replay, and that a handler return or a new instruction during a stall leaves the held payload intact.

// File: rtl/simd_gate_pkg.sv
package simd_gate_pkg;
  localparam int FAULT_N = 3;
  // bit order is also the priority order: lowest index wins
  localparam int FLT_UD = 0;
  localparam int FLT_NM = 1;
  localparam int FLT_MF = 2;
  typedef logic [FAULT_N-1:0] fault_vec_t;
endpackage

// File: rtl/simd_fault_prio.sv
module simd_fault_prio
  import simd_gate_pkg::*;
(
  input  logic       eval_i,
  input  logic       simd_i,
  input  logic       em_i,
  input  logic       ts_i,
  input  logic       fp_i,
  output fault_vec_t vec_o
);
  fault_vec_t raw;
  fault_vec_t blocked;

  always_comb begin
    raw         = '0;
    raw[FLT_UD] = em_i;
    raw[FLT_NM] = ts_i;
    raw[FLT_MF] = fp_i;
    if (!(eval_i && simd_i)) raw = '0;
  end

  // blocked[i]: some higher-priority condition is present
  assign blocked[0] = 1'b0;
  for (genvar i = 1; i < FAULT_N; i++) begin : g_chain
    assign blocked[i] = blocked[i-1] | raw[i-1];
  end

  assign vec_o = raw & ~blocked;
endmodule

// File: rtl/simd_replay_reg.sv
module simd_replay_reg #(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              clear_i,
  output logic              busy_o,
  output logic [DATA_W-1:0] data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o <= 1'b0;
      data_o <= '0;
    end else if (load_i) begin
      busy_o <= 1'b1;
      data_o <= data_i;
    end else if (clear_i) begin
      busy_o <= 1'b0;
    end
  end
endmodule

// File: rtl/simd_fault_gate.sv
module simd_fault_gate
  import simd_gate_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              instr_valid_i,
  input  logic              instr_simd_i,
  input  logic [DATA_W-1:0] instr_data_i,
  input  logic              ctrl_em_i,
  input  logic              ctrl_ts_i,
  input  logic              fp_pending_i,
  input  logic              handler_ret_i,
  output logic              issue_grant_o,
  output logic              issue_replay_o,
  output logic [DATA_W-1:0] issue_data_o,
  output logic              fault_valid_o,
  output logic [FAULT_N-1:0] fault_vec_o,
  output logic              stall_o
);
  logic              busy;
  logic [DATA_W-1:0] held_data;
  logic              eval_new, eval_rep, eval_any;
  logic              cand_simd;
  logic [DATA_W-1:0] cand_data;
  fault_vec_t        vec;
  logic              fault_any;

  assign eval_new  = instr_valid_i && !busy;
  assign eval_rep  = busy && handler_ret_i;   // replay wins over a new offer
  assign eval_any  = eval_new || eval_rep;
  assign cand_simd = eval_rep ? 1'b1 : instr_simd_i;
  assign cand_data = eval_rep ? held_data : instr_data_i;

  simd_fault_prio u_prio (
    .eval_i (eval_any),
    .simd_i (cand_simd),
    .em_i   (ctrl_em_i),
    .ts_i   (ctrl_ts_i),
    .fp_i   (fp_pending_i),
    .vec_o  (vec)
  );

  assign fault_any = |vec;

  simd_replay_reg #(.DATA_W(DATA_W)) u_replay (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (eval_new && fault_any),
    .data_i  (instr_data_i),
    .clear_i (eval_rep && !fault_any),
    .busy_o  (busy),
    .data_o  (held_data)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      issue_grant_o  <= 1'b0;
      issue_replay_o <= 1'b0;
      issue_data_o   <= '0;
      fault_valid_o  <= 1'b0;
      fault_vec_o    <= '0;
    end else begin
      issue_grant_o  <= eval_any && !fault_any;
      issue_replay_o <= eval_rep && !fault_any;
      fault_valid_o  <= fault_any;
      fault_vec_o    <= vec;
      if (eval_any && !fault_any) issue_data_o <= cand_data;
    end
  end

  assign stall_o = busy;
endmodule

// File: rtl/simd_fault_gate_chk.sv
module simd_fault_gate_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       instr_valid_i,
  input logic       instr_simd_i,
  input logic       ctrl_em_i,
  input logic       handler_ret_i,
  input logic       issue_grant_o,
  input logic       fault_valid_o,
  input logic [2:0] fault_vec_o,
  input logic       stall_o
);
  a_r5_grant_or_fault: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(issue_grant_o && fault_valid_o));

  a_r5_onehot_vec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_valid_o |-> $countones(fault_vec_o) == 1);

  a_r10_vec_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fault_valid_o |-> fault_vec_o == 3'b000);

  a_r10_strobe_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fault_valid_o) |-> $past((instr_valid_i && !stall_o) || (stall_o && handler_ret_i)));

  a_r2_em_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_valid_o && $past(ctrl_em_i)) |-> fault_vec_o == 3'b001);

  a_r7_non_simd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (instr_valid_i && !stall_o && !instr_simd_i) |=> (issue_grant_o && !fault_valid_o));

  a_r8_stall_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stall_o && !handler_ret_i) |=> (!issue_grant_o && !fault_valid_o && stall_o));

  a_r8_fault_stalls: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_valid_o |-> stall_o);
endmodule

bind simd_fault_gate simd_fault_gate_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .instr_valid_i (instr_valid_i),
  .instr_simd_i  (instr_simd_i),
  .ctrl_em_i     (ctrl_em_i),
  .handler_ret_i (handler_ret_i),
  .issue_grant_o (issue_grant_o),
  .fault_valid_o (fault_valid_o),
  .fault_vec_o   (fault_vec_o),
  .stall_o       (stall_o)
);

// File: tb/simd_fault_gate_tb.sv
module simd_fault_gate_tb;
  localparam int DATA_W = 32;
  localparam int NVEC   = 10;
  // {simd, em, ts, fp, exp_grant, exp_vec[2:0]}
  localparam logic [7:0] VECS [NVEC] = '{
    8'b1000_1_000, 8'b1100_0_001, 8'b1010_0_010, 8'b1001_0_100,
    8'b1111_0_001, 8'b1011_0_010, 8'b0111_1_000, 8'b0000_1_000,
    8'b1110_0_001, 8'b1101_0_001
  };

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic instr_valid_i = 1'b0, instr_simd_i = 1'b0;
  logic [DATA_W-1:0] instr_data_i = '0;
  logic ctrl_em_i = 1'b0, ctrl_ts_i = 1'b0, fp_pending_i = 1'b0, handler_ret_i = 1'b0;
  logic issue_grant_o, issue_replay_o, fault_valid_o, stall_o;
  logic [DATA_W-1:0] issue_data_o;
  logic [2:0] fault_vec_o;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  simd_fault_gate #(.DATA_W(DATA_W)) u_dut (.*);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // drive for one evaluated edge, leave outputs visible at the following negedge
  task automatic step(input logic v, input logic s, input logic em, input logic ts,
                      input logic fp, input logic ret, input logic [DATA_W-1:0] d);
    @(negedge clk_i);
    instr_valid_i = v; instr_simd_i = s; ctrl_em_i = em; ctrl_ts_i = ts;
    fp_pending_i = fp; handler_ret_i = ret; instr_data_i = d;
    @(negedge clk_i);
    instr_valid_i = 1'b0; handler_ret_i = 1'b0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    #35;
    // R1 reset state
    chk("R1 grant", issue_grant_o, 0);
    chk("R1 fault", fault_valid_o, 0);
    chk("R1 vec", fault_vec_o, 0);
    chk("R1 stall", stall_o, 0);
    rst_ni = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      logic [7:0] v;
      logic [DATA_W-1:0] d;
      v = VECS[i];
      d = 32'hA000 + i;
      step(1'b1, v[7], v[6], v[5], v[4], 1'b0, d);
      // R2 R3 R4 R5 R6 R7 per-vector fault code and grant
      chk($sformatf("R2-R7 vec%0d grant", i), issue_grant_o, v[3]);
      chk($sformatf("R5 vec%0d code", i), fault_vec_o, v[2:0]);
      chk($sformatf("R10 vec%0d strobe", i), fault_valid_o, |v[2:0]);
      if (v[3]) begin
        chk($sformatf("R6 vec%0d data", i), issue_data_o, d);
        chk($sformatf("R6 vec%0d replay flag", i), issue_replay_o, 0);
      end else begin
        chk($sformatf("R8 vec%0d stall", i), stall_o, 1);
        step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, '0);
        chk($sformatf("R9 vec%0d replay grant", i), issue_grant_o, 1);
        chk($sformatf("R9 vec%0d replay flag", i), issue_replay_o, 1);
        chk($sformatf("R9 vec%0d replay data", i), issue_data_o, d);
        chk($sformatf("R9 vec%0d stall clear", i), stall_o, 0);
      end
    end

    // R8: new offers ignored during stall, payload kept
    step(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 32'h1111);
    chk("R4 fp fault", fault_vec_o, 3'b100);
    step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h2222);
    chk("R8 ignored grant", issue_grant_o, 0);
    chk("R10 single pulse", fault_valid_o, 0);
    chk("R8 still stalled", stall_o, 1);
    // R9: replay faults again with TS set, stall remains
    step(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, '0);
    chk("R9 refault code", fault_vec_o, 3'b010);
    chk("R9 refault strobe", fault_valid_o, 1);
    chk("R9 refault stall", stall_o, 1);
    step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 32'h3333);
    chk("R9 replay wins", issue_data_o, 32'h1111);
    chk("R9 replay flag", issue_replay_o, 1);

    // R11: handler return while idle
    step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, '0);
    chk("R11 no grant", issue_grant_o, 0);
    chk("R11 no stall", stall_o, 0);
    chk("R11 no fault", fault_valid_o, 0);

    // R1: reset in the middle of a stall
    step(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 32'h4444);
    chk("R2 em fault", fault_vec_o, 3'b001);
    @(negedge clk_i); rst_ni = 1'b0;
    #1;
    chk("R1 midrun stall", stall_o, 0);
    chk("R1 midrun vec", fault_vec_o, 0);
    @(negedge clk_i); rst_ni = 1'b1;
    step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 32'h5555);
    chk("R6 after reset", issue_data_o, 32'h5555);

    done = 1'b1;
    summary();
  end
endmodule